// File: doc/BRIEF.md
# Per-Vector Interrupt Message Engine

This block turns internal interrupt request lines into posted memory writes. Each vector owns one table entry: a 64-bit target address, a 32-bit data word and a mask bit. The data word tells the host interrupt controller which interrupt to raise on which processor, so every vector can be steered on its own. Software fills and masks the table through a word-wide register port. It can also read a pending-bit array that records the vectors which fired while they could not be delivered.

A request pulse on `irq_in[v]` sets the pending bit of vector v. The engine scans the vectors that are pending and unmasked in round-robin order. It fetches the entry of the chosen vector and presents one message write at a time on a valid/ready channel. The vector's pending bit is cleared only when that write is accepted. A function-wide hold input stops every delivery and leaves the pending bits untouched. The engine tracks DMA writes that the same upstream path has accepted but not yet completed. It never raises a message while such a write is still outstanding, so an interrupt cannot overtake the data it announces.

Top module: `msgirq_engine`

## Requirements
- R1: Register word address layout. When the top address bit is 0, the table is selected: bits [1:0] pick the word (0 = target address bits 31:0, 1 = target address bits 63:32, 2 = data word, 3 = control) and the bits above them give the vector. Bit 0 of the control word is the vector mask, and control bits 31:1 read as zero. A read returns the last value written, with `reg_rvalid` high exactly one cycle after the request.
- R2: After reset every vector is masked, every pending bit is clear and `msg_valid` is low.
- R3: A message carries `{addr_hi, addr_lo}` of its vector on `msg_addr` and that vector's data word on `msg_data`. While `msg_valid` is high and `msg_ready` is low, the valid, address and data stay unchanged.
- R4: A request on a masked vector sets its pending bit and produces no message. Clearing the mask then delivers the message, and the pending bit is clear after the write is accepted.
- R5: While `fn_mask` is high no message is raised and the pending bits are kept. When it falls, the held vectors are delivered.
- R6: Pending, unmasked vectors are served round-robin. The scan starts at the vector after the last delivered one (vector 0 after reset) and wraps past the top.
- R7: At most one message is outstanding. A pending bit stays set until its write is accepted. A new request arriving in the accepting cycle leaves the bit set, so the vector is sent again.
- R8: `msg_valid` does not rise while any DMA write has been accepted (`dma_acc` pulse) and not yet completed (`dma_done` pulse).
- R9: When the top address bit is 1, the read returns pending bits 32w+31 down to 32w, where w is taken from the low address bits. Writes to this region have no effect.
- R10: A register write produces no `reg_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_req | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | log2(NUM_VEC)+3 | Word address (region bit, vector, word select) |
| reg_wdata | input | 32 | Write data |
| reg_rvalid | output | 1 | Read data valid, one cycle after a read request |
| reg_rdata | output | 32 | Read data |
| irq_in | input | NUM_VEC | Per-vector request pulses |
| fn_mask | input | 1 | Function-wide hold of all deliveries |
| dma_acc | input | 1 | One DMA write accepted upstream this cycle |
| dma_done | input | 1 | One earlier DMA write completed this cycle |
| msg_valid | output | 1 | Message write presented |
| msg_ready | input | 1 | Message write accepted when high with valid |
| msg_addr | output | 64 | Message target address |
| msg_data | output | 32 | Message data word |

## Verification
The bench fires a vector while it is masked and checks that nothing leaves the block while the pending readback shows the bit. A design that dropped the request or sent it anyway would fail there. It releases several pending vectors at once, right after a known last grant, and compares the delivery order with a round-robin model. A fixed-priority picker, or one that restarts at vector 0, would show a different order. A request is timed to land in the very cycle its own message is accepted, and the bench expects a second message. A design that let the clear win would lose that interrupt. Finally, DMA writes are left outstanding while a vector is ready, to show that no message rises until the last completion arrives.

// File: rtl/msgirq_pkg.sv
package msgirq_pkg;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_LOAD = 2'd1,
        ENG_WAIT = 2'd2,
        ENG_SEND = 2'd3
    } eng_state_e;

    localparam int          WORD_W       = 32;
    localparam int          ENTRY_WORDS  = 3;
    localparam logic [1:0]  WSEL_ADDR_LO = 2'd0;
    localparam logic [1:0]  WSEL_ADDR_HI = 2'd1;
    localparam logic [1:0]  WSEL_DATA    = 2'd2;
    localparam logic [1:0]  WSEL_CTRL    = 2'd3;

endpackage

// File: rtl/msgirq_rr_pick.sv
module msgirq_rr_pick #(
    parameter int N = 64
) (
    input  logic [N-1:0]         cand,
    input  logic [$clog2(N)-1:0] start,
    output logic                 hit,
    output logic [$clog2(N)-1:0] idx
);
    localparam int W = $clog2(N);

    logic [W-1:0] probe;

    // first candidate at or above start, wrapping through the top
    always_comb begin
        hit   = 1'b0;
        idx   = start;
        probe = start;
        for (int i = 0; i < N; i++) begin
            probe = start + W'(i);
            if (!hit && cand[probe]) begin
                hit = 1'b1;
                idx = probe;
            end
        end
    end
endmodule

// File: rtl/msgirq_vec_table.sv
module msgirq_vec_table
    import msgirq_pkg::*;
#(
    parameter int N = 64
) (
    input  logic                          clk,
    input  logic                          wr_en,
    input  logic [$clog2(N)-1:0]          wr_vec,
    input  logic [1:0]                    wr_sel,
    input  logic [WORD_W-1:0]             wr_data,
    input  logic [$clog2(N)-1:0]          rd_a_vec,
    output logic [ENTRY_WORDS*WORD_W-1:0] rd_a_q,
    input  logic [$clog2(N)-1:0]          rd_b_vec,
    output logic [ENTRY_WORDS*WORD_W-1:0] rd_b_q
);
    // one inferred bank per stored word, each with a register-port read
    // and an engine read
    for (genvar g = 0; g < ENTRY_WORDS; g++) begin : g_bank
        logic [WORD_W-1:0] bank [N];
        logic [WORD_W-1:0] qa;
        logic [WORD_W-1:0] qb;

        always_ff @(posedge clk) begin
            if (wr_en && wr_sel == 2'(g)) begin
                bank[wr_vec] <= wr_data;
            end
            qa <= bank[rd_a_vec];
            qb <= bank[rd_b_vec];
        end

        assign rd_a_q[g*WORD_W +: WORD_W] = qa;
        assign rd_b_q[g*WORD_W +: WORD_W] = qb;
    end
endmodule

// File: rtl/msgirq_engine.sv
module msgirq_engine
    import msgirq_pkg::*;
#(
    parameter int NUM_VEC = 64,
    parameter int DMA_CW  = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_req,
    input  logic                         reg_we,
    input  logic [$clog2(NUM_VEC)+2:0]   reg_addr,
    input  logic [31:0]                  reg_wdata,
    output logic                         reg_rvalid,
    output logic [31:0]                  reg_rdata,
    input  logic [NUM_VEC-1:0]           irq_in,
    input  logic                         fn_mask,
    input  logic                         dma_acc,
    input  logic                         dma_done,
    output logic                         msg_valid,
    input  logic                         msg_ready,
    output logic [63:0]                  msg_addr,
    output logic [31:0]                  msg_data
);
    localparam int VW  = $clog2(NUM_VEC);
    localparam int RAW = VW + 3;
    localparam int PWN = NUM_VEC / WORD_W;
    localparam int PWW = $clog2(PWN);
    localparam int EW  = ENTRY_WORDS * WORD_W;

    typedef struct packed {
        eng_state_e           fsm;
        logic [VW-1:0]        sel;
        logic [VW-1:0]        rr;
        logic [NUM_VEC-1:0]   pend;
        logic [NUM_VEC-1:0]   mask;
        logic [DMA_CW-1:0]    dma_cnt;
        logic                 msg_valid;
        logic [63:0]          msg_addr;
        logic [31:0]          msg_data;
        logic                 rvalid;
        logic                 rd_pba;
        logic [1:0]           rd_sel;
        logic [31:0]          rd_side;
    } eng_st_t;

    eng_st_t st_d, st_q;

    // register port decode
    logic              reg_pba;
    logic [VW-1:0]     reg_vec;
    logic [1:0]        reg_sel;
    logic [PWW-1:0]    reg_pw;
    logic              tbl_we;

    assign reg_pba = reg_addr[RAW-1];
    assign reg_vec = reg_addr[VW+1:2];
    assign reg_sel = reg_addr[1:0];
    assign reg_pw  = reg_addr[PWW-1:0];
    assign tbl_we  = reg_req && reg_we && !reg_pba && (reg_sel != WSEL_CTRL);

    // arbitration among deliverable vectors
    logic [NUM_VEC-1:0] eligible;
    logic               pick_hit;
    logic [VW-1:0]      pick_idx;

    assign eligible = st_q.pend & ~st_q.mask & {NUM_VEC{~fn_mask}};

    msgirq_rr_pick #(.N(NUM_VEC)) i_pick (
        .cand  (eligible),
        .start (st_q.rr),
        .hit   (pick_hit),
        .idx   (pick_idx)
    );

    logic [EW-1:0] tbl_reg_q;
    logic [EW-1:0] tbl_eng_q;

    msgirq_vec_table #(.N(NUM_VEC)) i_table (
        .clk      (clk),
        .wr_en    (tbl_we),
        .wr_vec   (reg_vec),
        .wr_sel   (reg_sel),
        .wr_data  (reg_wdata),
        .rd_a_vec (reg_vec),
        .rd_a_q   (tbl_reg_q),
        .rd_b_vec (pick_idx),
        .rd_b_q   (tbl_eng_q)
    );

    logic              accept;
    logic              sel_held;
    logic [DMA_CW-1:0] dma_inc;

    always_comb begin
        st_d     = st_q;
        accept   = st_q.msg_valid && msg_ready;
        sel_held = st_q.mask[st_q.sel] || fn_mask;

        // outstanding DMA writes seen by the same upstream path
        dma_inc = st_q.dma_cnt + DMA_CW'(dma_acc);
        if (dma_done && dma_inc != '0) begin
            st_d.dma_cnt = dma_inc - DMA_CW'(1);
        end else begin
            st_d.dma_cnt = dma_inc;
        end

        unique case (st_q.fsm)
            ENG_IDLE: begin
                if (pick_hit) begin
                    st_d.sel = pick_idx;
                    st_d.fsm = ENG_LOAD;
                end
            end
            ENG_LOAD: begin
                if (sel_held) begin
                    st_d.fsm = ENG_IDLE;
                end else begin
                    st_d.msg_addr = {tbl_eng_q[2*WORD_W-1:WORD_W], tbl_eng_q[WORD_W-1:0]};
                    st_d.msg_data = tbl_eng_q[3*WORD_W-1:2*WORD_W];
                    if (st_d.dma_cnt == '0) begin
                        st_d.msg_valid = 1'b1;
                        st_d.fsm       = ENG_SEND;
                    end else begin
                        st_d.fsm       = ENG_WAIT;
                    end
                end
            end
            ENG_WAIT: begin
                if (sel_held) begin
                    st_d.fsm = ENG_IDLE;
                end else if (st_d.dma_cnt == '0) begin
                    st_d.msg_valid = 1'b1;
                    st_d.fsm       = ENG_SEND;
                end
            end
            ENG_SEND: begin
                if (accept) begin
                    st_d.msg_valid      = 1'b0;
                    st_d.pend[st_q.sel] = 1'b0;
                    st_d.rr             = st_q.sel + VW'(1);
                    st_d.fsm            = ENG_IDLE;
                end
            end
            default: st_d.fsm = ENG_IDLE;
        endcase

        // a fresh request wins over the clear of the same cycle
        st_d.pend = st_d.pend | irq_in;

        // register side
        if (reg_req && reg_we && !reg_pba && reg_sel == WSEL_CTRL) begin
            st_d.mask[reg_vec] = reg_wdata[0];
        end
        st_d.rvalid = reg_req && !reg_we;
        if (reg_req && !reg_we) begin
            st_d.rd_pba = reg_pba;
            st_d.rd_sel = reg_sel;
            if (reg_pba) begin
                st_d.rd_side = st_q.pend[{reg_pw, 5'b0} +: WORD_W];
            end else begin
                st_d.rd_side = {31'b0, st_q.mask[reg_vec]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
        end else begin
            st_q      <= st_d;
        end
    end

    always_comb begin
        if (st_q.rd_pba || st_q.rd_sel == WSEL_CTRL) begin
            reg_rdata = st_q.rd_side;
        end else begin
            reg_rdata = tbl_reg_q[{st_q.rd_sel, 5'b0} +: WORD_W];
        end
    end

    assign reg_rvalid = st_q.rvalid;
    assign msg_valid  = st_q.msg_valid;
    assign msg_addr   = st_q.msg_addr;
    assign msg_data   = st_q.msg_data;

endmodule

// File: rtl/msgirq_engine_chk.sv
module msgirq_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_req,
    input logic        reg_we,
    input logic        reg_rvalid,
    input logic        fn_mask,
    input logic        dma_acc,
    input logic        dma_done,
    input logic        msg_valid,
    input logic        msg_ready,
    input logic [63:0] msg_addr,
    input logic [31:0] msg_data
);
    // independent count of DMA writes accepted and not yet completed
    logic [15:0] ck_out;
    logic [15:0] ck_inc;

    assign ck_inc = ck_out + 16'(dma_acc);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_out <= '0;
        end else if (dma_done && ck_inc != '0) begin
            ck_out <= ck_inc - 16'd1;
        end else begin
            ck_out <= ck_inc;
        end
    end

    assert_rd_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_we) |=> reg_rvalid);

    assert_wr_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_we) |=> !reg_rvalid);

    assert_msg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

    assert_dma_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> (ck_out == 16'd0));

    assert_fn_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> !$past(fn_mask));

endmodule

bind msgirq_engine msgirq_engine_chk i_msgirq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_req    (reg_req),
    .reg_we     (reg_we),
    .reg_rvalid (reg_rvalid),
    .fn_mask    (fn_mask),
    .dma_acc    (dma_acc),
    .dma_done   (dma_done),
    .msg_valid  (msg_valid),
    .msg_ready  (msg_ready),
    .msg_addr   (msg_addr),
    .msg_data   (msg_data)
);

// File: tb/test_msgirq_engine.sv
`timescale 1ns/1ps
module test_msgirq_engine;
    localparam int NV  = 64;
    localparam int VW  = 6;
    localparam int RAW = VW + 3;
    localparam int PWN = NV / 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_req = 1'b0, reg_we = 1'b0;
    logic [RAW-1:0]  reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic            reg_rvalid;
    logic [31:0]     reg_rdata;
    logic [NV-1:0]   irq_in = '0;
    logic            fn_mask = 1'b0, dma_acc = 1'b0, dma_done = 1'b0;
    logic            msg_valid, msg_ready = 1'b0;
    logic [63:0]     msg_addr;
    logic [31:0]     msg_data;

    always #2.5 clk = ~clk;

    msgirq_engine #(.NUM_VEC(NV)) i_msgirq_engine (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid),
        .reg_rdata(reg_rdata), .irq_in(irq_in), .fn_mask(fn_mask),
        .dma_acc(dma_acc), .dma_done(dma_done), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data));

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    // reference model
    logic [31:0]   m_lo [NV];
    logic [31:0]   m_hi [NV];
    logic [31:0]   m_dat [NV];
    bit            m_mask [NV];
    bit [NV-1:0]   m_pend = '0;
    int            m_rr = 0;
    int            msg_cnt = 0;
    int            log_q [$];

    int            rdy_mode = 0;   // 0 always, 1 random, 2 never, 3 one accept with re-request
    bit            rnd_irq = 0;
    bit [NV-1:0]   irq_q = '0;
    bit            hold_prev = 0;
    logic [63:0]   prev_addr;
    logic [31:0]   prev_data;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    function automatic logic [RAW-1:0] tbl_addr(input int v, input int w);
        return {1'b0, VW'(v), 2'(w)};
    endfunction

    function automatic logic [RAW-1:0] pba_addr(input int w);
        return {1'b1, (RAW-1)'(w)};
    endfunction

    function automatic int next_rr(input int ptr, input bit [NV-1:0] s);
        for (int i = 0; i < NV; i++) begin
            if (s[(ptr + i) % NV]) return (ptr + i) % NV;
        end
        return -1;
    endfunction

    // message sink, request driver and model update
    always @(negedge clk) begin
        logic r;
        int v;
        if (rst_n) begin
            if (hold_prev) begin
                chk(msg_valid === 1'b1 && msg_addr == prev_addr, "R3 hold addr", msg_addr, prev_addr);
                chk(msg_data == prev_data, "R3 hold data", 64'(msg_data), 64'(prev_data));
            end
            case (rdy_mode)
                0: r = 1'b1;
                1: r = 1'($urandom_range(0, 1));
                2: r = 1'b0;
                default: r = 1'b1;
            endcase
            msg_ready = r;
            irq_in = irq_q;
            irq_q = '0;
            if (rnd_irq && $urandom_range(0, 2) == 0) irq_in[$urandom_range(0, NV-1)] = 1'b1;
            if (msg_valid && r) begin
                v = int'(msg_data[VW-1:0]);
                chk(msg_addr == {m_hi[v], m_lo[v]}, "R3 addr", msg_addr, {m_hi[v], m_lo[v]});
                chk(msg_data == m_dat[v], "R3 data", 64'(msg_data), 64'(m_dat[v]));
                chk(!m_mask[v], "R4 sent while masked", 64'(m_mask[v]), 64'd0);
                chk(m_pend[v], "R7 sent without pending", 64'(m_pend[v]), 64'd1);
                m_pend[v] = 1'b0;
                m_rr = (v + 1) % NV;
                log_q.push_back(v);
                msg_cnt++;
                if (rdy_mode == 3) begin
                    irq_in[v] = 1'b1;
                    rdy_mode = 2;
                end
            end
            m_pend = m_pend | irq_in;
            hold_prev = msg_valid && !r;
            prev_addr = msg_addr;
            prev_data = msg_data;
        end
    end

    task automatic reg_wr(input logic [RAW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_req = 1'b0; reg_we = 1'b0;
        chk(reg_rvalid == 1'b0, "R10 rvalid after write", 64'(reg_rvalid), 64'd0);
    endtask

    task automatic reg_rd(input logic [RAW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_req = 1'b1; reg_we = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_req = 1'b0;
        chk(reg_rvalid == 1'b1, "R1 rvalid latency", 64'(reg_rvalid), 64'd1);
        d = reg_rdata;
    endtask

    task automatic set_mask(input int v, input bit m);
        reg_wr(tbl_addr(v, 3), {31'b0, m});
        m_mask[v] = m;
    endtask

    task automatic chk_pend(input string tag);
        logic [31:0] d;
        for (int w = 0; w < PWN; w++) begin
            reg_rd(pba_addr(w), d);
            chk(d == m_pend[w*32 +: 32], tag, 64'(d), 64'(m_pend[w*32 +: 32]));
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [31:0] d;
        int base, exp_v, ptr;
        bit [NV-1:0] s;
        void'($urandom(32'h0001_D00D));
        for (int v = 0; v < NV; v++) m_mask[v] = 1'b1;
        idle(5);
        rst_n = 1'b1;
        idle(2);

        // R2 reset state
        chk(msg_valid == 1'b0, "R2 msg_valid", 64'(msg_valid), 64'd0);
        reg_rd(tbl_addr(0, 3), d);
        chk(d == 32'd1, "R2 mask v0", 64'(d), 64'd1);
        reg_rd(tbl_addr(NV-1, 3), d);
        chk(d == 32'd1, "R2 mask top", 64'(d), 64'd1);
        chk_pend("R2 pending clear");

        // R1 program the table and read back
        for (int v = 0; v < NV; v++) begin
            m_lo[v]  = $urandom();
            m_hi[v]  = $urandom();
            m_dat[v] = {$urandom() >> VW, VW'(v)};
            reg_wr(tbl_addr(v, 0), m_lo[v]);
            reg_wr(tbl_addr(v, 1), m_hi[v]);
            reg_wr(tbl_addr(v, 2), m_dat[v]);
        end
        foreach (m_lo[v]) begin
            if (v == 0 || v == 17 || v == NV-1) begin
                reg_rd(tbl_addr(v, 0), d);
                chk(d == m_lo[v], "R1 addr_lo", 64'(d), 64'(m_lo[v]));
                reg_rd(tbl_addr(v, 1), d);
                chk(d == m_hi[v], "R1 addr_hi", 64'(d), 64'(m_hi[v]));
                reg_rd(tbl_addr(v, 2), d);
                chk(d == m_dat[v], "R1 data", 64'(d), 64'(m_dat[v]));
            end
        end
        reg_wr(tbl_addr(20, 3), 32'hFFFF_FFFF);
        reg_rd(tbl_addr(20, 3), d);
        chk(d == 32'd1, "R1 control upper bits", 64'(d), 64'd1);

        // R4 request while masked, then unmask
        base = msg_cnt;
        irq_q[7] = 1'b1;
        idle(20);
        chk(msg_cnt == base, "R4 no message while masked", 64'(msg_cnt), 64'(base));
        chk_pend("R4 pending held");
        set_mask(7, 1'b0);
        idle(10);
        chk(msg_cnt == base + 1 && log_q[$] == 7, "R4 delivered on unmask", 64'(log_q[$]), 64'd7);
        chk_pend("R4 pending cleared");

        // R9 pending region ignores writes
        irq_q[45] = 1'b1;
        idle(10);
        for (int w = 0; w < PWN; w++) reg_wr(pba_addr(w), 32'hFFFF_FFFF);
        reg_wr(pba_addr(1), 32'h0000_0000);
        chk_pend("R9 pending after writes");

        // R5 + R6 function-wide hold, then round-robin release
        foreach (m_lo[v]) if (v == 3 || v == 5 || v == 9 || v == 40 || v == 50) set_mask(v, 1'b0);
        fn_mask = 1'b1;
        base = msg_cnt;
        irq_q[5] = 1'b1; irq_q[40] = 1'b1; irq_q[9] = 1'b1;
        idle(20);
        chk(msg_cnt == base, "R5 held by fn_mask", 64'(msg_cnt), 64'(base));
        chk_pend("R5 pending kept");
        log_q.delete();
        s = '0; s[5] = 1; s[9] = 1; s[40] = 1;
        ptr = m_rr;
        fn_mask = 1'b0;
        idle(25);
        chk(log_q.size() == 3, "R5 release count", 64'(log_q.size()), 64'd3);
        for (int k = 0; k < 3; k++) begin
            exp_v = next_rr(ptr, s);
            s[exp_v] = 0; ptr = (exp_v + 1) % NV;
            chk(k < log_q.size() && log_q[k] == exp_v, "R6 order", 64'(k < log_q.size() ? log_q[k] : -1), 64'(exp_v));
        end
        fn_mask = 1'b1;
        irq_q[3] = 1'b1; irq_q[9] = 1'b1; irq_q[50] = 1'b1;
        idle(10);
        log_q.delete();
        s = '0; s[3] = 1; s[9] = 1; s[50] = 1;
        ptr = m_rr;
        fn_mask = 1'b0;
        idle(25);
        for (int k = 0; k < 3; k++) begin
            exp_v = next_rr(ptr, s);
            s[exp_v] = 0; ptr = (exp_v + 1) % NV;
            chk(k < log_q.size() && log_q[k] == exp_v, "R6 wrap order", 64'(k < log_q.size() ? log_q[k] : -1), 64'(exp_v));
        end

        // R8 DMA ordering
        base = msg_cnt;
        @(negedge clk); dma_acc = 1'b1;
        @(negedge clk); dma_acc = 1'b1;
        @(negedge clk); dma_acc = 1'b0;
        irq_q[5] = 1'b1;
        idle(15);
        chk(msg_valid == 1'b0 && msg_cnt == base, "R8 held by two DMA", 64'(msg_cnt), 64'(base));
        @(negedge clk); dma_done = 1'b1;
        @(negedge clk); dma_done = 1'b0;
        idle(10);
        chk(msg_valid == 1'b0 && msg_cnt == base, "R8 held by one DMA", 64'(msg_cnt), 64'(base));
        @(negedge clk); dma_done = 1'b1;
        @(negedge clk); dma_done = 1'b0;
        idle(10);
        chk(msg_cnt == base + 1, "R8 sent after completion", 64'(msg_cnt), 64'(base + 1));

        // R7 pending kept until accept, request in accept cycle re-pends
        rdy_mode = 2;
        base = msg_cnt;
        irq_q[9] = 1'b1;
        idle(10);
        chk(msg_valid == 1'b1, "R7 message waiting", 64'(msg_valid), 64'd1);
        chk_pend("R7 pending before accept");
        rdy_mode = 3;
        idle(8);
        chk(msg_valid == 1'b1 && msg_data[VW-1:0] == 9, "R7 resent after set-wins", 64'(msg_data[VW-1:0]), 64'd9);
        chk_pend("R7 pending after set-wins");
        rdy_mode = 0;
        idle(10);
        chk(msg_cnt == base + 2, "R7 two deliveries", 64'(msg_cnt), 64'(base + 2));
        chk_pend("R7 pending drained");

        // random traffic over a static mask pattern
        foreach (m_lo[v]) set_mask(v, ($urandom_range(0, 3) == 0));
        rdy_mode = 1;
        rnd_irq = 1;
        idle(4000);
        rnd_irq = 0;
        rdy_mode = 0;
        idle(300);
        chk_pend("R4 random drain");
        s = '0;
        foreach (m_mask[v]) s[v] = !m_mask[v];
        chk((m_pend & s) == '0, "R4 unmasked all drained", 64'(m_pend & s), 64'd0);

        report();
    end
endmodule